// File: doc/BRIEF.md
# Serial EEPROM Boot Loader Sequencer

This block fetches a fixed image from a serial three-wire EEPROM, of the kind that takes a start bit, an opcode and an address on rising serial-clock edges, and passes it to the rest of the chip one word at a time. A load starts in two ways. The first is the release of the synchronous hard reset. The second is a one-cycle software request while the block is idle. While it reads, the block adds up every byte of the image and then reports whether the image holds a valid checksum.

On a load started by reset, the block first samples a board strap that says whether an EEPROM is fitted. If the strap reads absent, the block drives only two serial clocks and then gives up, leaving the valid flag clear. A software-requested load ignores the strap. It always reads the whole image, and only the checksum decides the flag. Each received word appears on a word bus with its index and a one-cycle write strobe, so a register file next to the block can capture it.

Top module: `eeload_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that samples it high, `read_active`, `mem_cs`, `mem_sck`, `word_we` and `load_valid` are all 0.
- R2: On the first clock after reset is released with `strap_present` = 1, the block performs a full read of 9 command clocks plus 256 data clocks (265 rising `mem_sck` edges) and delivers 16 words.
- R3: On the first clock after reset is released with `strap_present` = 0, the block drives exactly two rising `mem_sck` edges and then drops `mem_cs`. It delivers no word and leaves `load_valid` at 0.
- R4: After `mem_cs` rises, the values on `mem_dout` at the first nine rising `mem_sck` edges are, in order, 1, 1, 0 and then six zeros (start bit, read opcode 10 and word address 0, most significant bit first).
- R5: From the tenth rising edge on, each rising edge presents one data bit on `mem_din`, most significant bit first, 16 bits per word. Each completed word appears on `word_data` with a one-cycle `word_we` pulse, and `word_addr` counts 0 to 15 in order.
- R6: After a full read, `load_valid` is 1 exactly when the sum of all 32 bytes of the 16 words, modulo 256, equals 0xFF. Otherwise it is 0.
- R7: A one-cycle `sw_read_req` while idle starts a full 265-clock read whatever the level of `strap_present`.
- R8: `read_active` is 1 from the clock that starts a sequence until that sequence ends or aborts. A `sw_read_req` that arrives while it is 1 has no effect.
- R9: `load_valid` is forced to 0 in the clock that starts any sequence and stays 0 while `read_active` is 1.
- R10: `mem_sck` has a period of `CLK_DIV` clocks. `mem_cs` rises `CLK_DIV/2` clocks before the first rising `mem_sck` edge. When idle, both `mem_cs` and `mem_sck` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset; a load starts when it is released |
| strap_present | input | 1 | Board strap, 1 when an EEPROM is fitted |
| sw_read_req | input | 1 | One-cycle software request for a full load |
| mem_cs | output | 1 | EEPROM chip select |
| mem_sck | output | 1 | EEPROM serial clock |
| mem_dout | output | 1 | Serial command bits to the EEPROM |
| mem_din | input | 1 | Serial data from the EEPROM |
| word_data | output | WORD_W (16) | Most recently assembled word |
| word_addr | output | log2(WORDS) (4) | Index of that word |
| word_we | output | 1 | One-cycle strobe for a new word |
| read_active | output | 1 | A load sequence is in progress |
| load_valid | output | 1 | The last full load had a good checksum |

## Verification
Most internal errors show up at the EEPROM pins within one serial clock. A bit counter that is off by one changes the number of rising `mem_sck` edges (265 for a full read, 2 for an abort). A wrong command index corrupts the nine bits the EEPROM model records. An error in the word assembler shows up as a wrong value, a wrong index or a missing strobe on the word bus, within 16 serial clocks of the fault. Errors in the checksum or the strap logic show only at the end of a sequence, when `load_valid` settles. To catch them, the bench runs a sweep of images whose byte sums are built to pass or to fail by computation.

// File: rtl/eeload_pkg.sv
package eeload_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic cs;
        logic sck;
        logic dout;
    } mw_pins_t;

    localparam int unsigned OPCODE_BITS = 3;
    localparam logic [7:0]  SUM_TARGET  = 8'hFF;

    function automatic logic cmd_bit(input int unsigned idx);
        logic b;
        case (idx)
            0:       b = 1'b1;
            1:       b = 1'b1;
            default: b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/eeload_divider.sv
module eeload_divider #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_tick
);
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    assign half_tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (half_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/eeload_assembler.sv
module eeload_assembler #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     sample_en,
    input  logic                     din,
    output logic [WORD_W-1:0]        word_data,
    output logic [$clog2(WORDS)-1:0] word_addr,
    output logic                     word_we,
    output logic                     sum_ok
);
    import eeload_pkg::*;

    localparam int unsigned BC_W   = $clog2(WORD_W);
    localparam int unsigned AW     = $clog2(WORDS);
    localparam int unsigned NBYTES = WORD_W / 8;
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

    logic [WORD_W-1:0] shreg_q;
    logic [BC_W-1:0]   bit_q;
    logic [AW-1:0]     idx_q;
    logic [7:0]        sum_q;
    logic [WORD_W-1:0] data_q;
    logic [AW-1:0]     addr_q;
    logic              we_q;
    logic [WORD_W-1:0] next_word;

    function automatic logic [7:0] byte_sum(input logic [WORD_W-1:0] w);
        logic [7:0] acc;
        acc = 8'd0;
        for (int i = 0; i < int'(NBYTES); i++) begin
            acc = acc + w[i*8 +: 8];
        end
        return acc;
    endfunction

    assign next_word = {shreg_q[WORD_W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg_q <= '0;
            bit_q   <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (sample_en) begin
                shreg_q <= next_word;
                if (bit_q == LAST_BIT) begin
                    bit_q  <= '0;
                    data_q <= next_word;
                    addr_q <= idx_q;
                    we_q   <= 1'b1;
                    idx_q  <= idx_q + 1'b1;
                    sum_q  <= sum_q + byte_sum(next_word);
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    assign word_data = data_q;
    assign word_addr = addr_q;
    assign word_we   = we_q;
    assign sum_ok    = (sum_q == SUM_TARGET);
endmodule

// File: rtl/eeload_ctrl.sv
module eeload_ctrl #(
    parameter int unsigned CMD_BITS   = 9,
    parameter int unsigned TOTAL_BITS = 265,
    parameter int unsigned ABORT_CLKS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sw_req,
    input  logic                      strap,
    input  logic                      half_tick,
    input  logic                      sum_ok,
    output logic                      run,
    output eeload_pkg::mw_pins_t      pins,
    output logic                      sample_en,
    output logic                      clear,
    output logic                      busy,
    output logic                      valid
);
    import eeload_pkg::*;

    localparam int unsigned BIT_W = $clog2(TOTAL_BITS);
    localparam logic [BIT_W-1:0] LAST_IDX  = BIT_W'(TOTAL_BITS - 1);
    localparam logic [BIT_W-1:0] ABORT_IDX = BIT_W'(ABORT_CLKS - 1);
    localparam logic [BIT_W-1:0] CMD_END   = BIT_W'(CMD_BITS);

    seq_state_e       state_q;
    logic [BIT_W-1:0] idx_q;
    logic             boot_pend_q;
    logic             abort_q;
    logic             valid_q;
    logic             start;
    logic             last_clk;

    assign start    = (state_q == SEQ_IDLE) && (boot_pend_q || sw_req);
    assign last_clk = (abort_q && idx_q == ABORT_IDX) || (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            idx_q       <= '0;
            boot_pend_q <= 1'b1;
            abort_q     <= 1'b0;
            valid_q     <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        abort_q     <= boot_pend_q && !strap;
                        boot_pend_q <= 1'b0;
                        idx_q       <= '0;
                        valid_q     <= 1'b0;
                        state_q     <= SEQ_LOW;
                    end
                end
                SEQ_LOW: begin
                    if (half_tick) state_q <= SEQ_HIGH;
                end
                SEQ_HIGH: begin
                    if (half_tick) begin
                        if (last_clk) begin
                            state_q <= SEQ_DONE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= SEQ_LOW;
                        end
                    end
                end
                SEQ_DONE: begin
                    valid_q <= !abort_q && sum_ok;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign run       = (state_q == SEQ_LOW) || (state_q == SEQ_HIGH);
    assign pins.cs   = run;
    assign pins.sck  = (state_q == SEQ_HIGH);
    assign pins.dout = run && (idx_q < CMD_END) && cmd_bit(int'(idx_q));
    assign sample_en = (state_q == SEQ_HIGH) && half_tick && (idx_q >= CMD_END);
    assign clear     = start;
    assign busy      = (state_q != SEQ_IDLE);
    assign valid     = valid_q;
endmodule

// File: rtl/eeload_seq.sv
module eeload_seq #(
    parameter int unsigned CLK_DIV = 4,
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned WORDS   = 16,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strap_present,
    input  logic                     sw_read_req,
    output logic                     mem_cs,
    output logic                     mem_sck,
    output logic                     mem_dout,
    input  logic                     mem_din,
    output logic [WORD_W-1:0]        word_data,
    output logic [$clog2(WORDS)-1:0] word_addr,
    output logic                     word_we,
    output logic                     read_active,
    output logic                     load_valid
);
    import eeload_pkg::*;

    localparam int unsigned HALF       = CLK_DIV / 2;
    localparam int unsigned CMD_BITS   = OPCODE_BITS + ADDR_W;
    localparam int unsigned TOTAL_BITS = CMD_BITS + WORDS * WORD_W;

    logic     run;
    logic     half_tick;
    logic     sample_en;
    logic     clear;
    logic     sum_ok;
    mw_pins_t pins;

    eeload_divider #(.HALF(HALF)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half_tick (half_tick)
    );

    eeload_ctrl #(
        .CMD_BITS   (CMD_BITS),
        .TOTAL_BITS (TOTAL_BITS),
        .ABORT_CLKS (2)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sw_req    (sw_read_req),
        .strap     (strap_present),
        .half_tick (half_tick),
        .sum_ok    (sum_ok),
        .run       (run),
        .pins      (pins),
        .sample_en (sample_en),
        .clear     (clear),
        .busy      (read_active),
        .valid     (load_valid)
    );

    eeload_assembler #(.WORD_W(WORD_W), .WORDS(WORDS)) u_asm (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .sample_en (sample_en),
        .din       (mem_din),
        .word_data (word_data),
        .word_addr (word_addr),
        .word_we   (word_we),
        .sum_ok    (sum_ok)
    );

    assign mem_cs   = pins.cs;
    assign mem_sck  = pins.sck;
    assign mem_dout = pins.dout;
endmodule

// File: rtl/eeload_seq_chk.sv
module eeload_seq_chk (
    input logic clk,
    input logic rst,
    input logic mem_cs,
    input logic mem_sck,
    input logic word_we,
    input logic read_active,
    input logic load_valid
);
    // R1: reset leaves every output quiet on the following cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!read_active && !mem_cs && !mem_sck && !word_we && !load_valid));

    // R10: serial clock only inside chip select; idle pins low
    p_sck_in_cs_r10: assert property (@(posedge clk) disable iff (rst)
        mem_sck |-> mem_cs);
    p_idle_pins_r10: assert property (@(posedge clk) disable iff (rst)
        !read_active |-> (!mem_cs && !mem_sck));

    // R9: no valid flag while a sequence runs
    p_valid_busy_r9: assert property (@(posedge clk) disable iff (rst)
        read_active |-> !load_valid);

    // R5: words are only delivered during a sequence
    p_we_busy_r5: assert property (@(posedge clk) disable iff (rst)
        word_we |-> read_active);

    // R6: the valid flag only moves at a sequence boundary
    p_valid_edge_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(load_valid) |-> ($fell(read_active) || $rose(read_active)));
endmodule

bind eeload_seq eeload_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_cs      (mem_cs),
    .mem_sck     (mem_sck),
    .word_we     (word_we),
    .read_active (read_active),
    .load_valid  (load_valid)
);

// File: tb/eeload_seq_tb_top.sv
`timescale 1ns/1ps
module eeload_seq_tb_top;
    localparam int CLK_DIV = 4;
    localparam int NW      = 16;
    localparam int FULL    = 9 + NW * 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_present = 1'b1;
    logic        sw_read_req = 1'b0;
    logic        mem_cs, mem_sck, mem_dout;
    logic        mem_din = 1'b0;
    logic [15:0] word_data;
    logic [3:0]  word_addr;
    logic        word_we, read_active, load_valid;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    eeload_seq #(.CLK_DIV(CLK_DIV)) dut_i (
        .clk(clk), .rst(rst), .strap_present(strap_present), .sw_read_req(sw_read_req),
        .mem_cs(mem_cs), .mem_sck(mem_sck), .mem_dout(mem_dout), .mem_din(mem_din),
        .word_data(word_data), .word_addr(word_addr), .word_we(word_we),
        .read_active(read_active), .load_valid(load_valid)
    );

    // EEPROM model
    logic [15:0] image [NW];
    int          edge_n = 0;
    logic [8:0]  cmd_seen = '0;

    always @(posedge mem_cs or posedge mem_sck) begin
        if (mem_cs && !mem_sck) begin
            edge_n   = 0;
            cmd_seen = '0;
        end else if (mem_cs) begin
            if (edge_n < 9) cmd_seen = {cmd_seen[7:0], mem_dout};
            else begin
                int k;
                k = edge_n - 9;
                if (k < NW * 16) mem_din = image[k / 16][15 - (k % 16)];
            end
            edge_n++;
        end
    end

    // Port monitor
    logic [15:0] cap_data [512];
    logic [3:0]  cap_addr [512];
    int cap_total = 0;
    int cyc = 0, cs_t = 0, rise1_t = 0, rise2_t = 0, rise_n = 0;
    logic prev_cs = 1'b0, prev_sck = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (word_we && cap_total < 512) begin
            cap_data[cap_total] = word_data;
            cap_addr[cap_total] = word_addr;
            cap_total = cap_total + 1;
        end
        if (mem_cs && !prev_cs) begin cs_t = cyc; rise_n = 0; end
        if (mem_sck && !prev_sck) begin
            if (rise_n == 0) rise1_t = cyc;
            if (rise_n == 1) rise2_t = cyc;
            rise_n = rise_n + 1;
        end
        prev_cs  = mem_cs;
        prev_sck = mem_sck;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic make_image(input int seed, input bit pass);
        logic [7:0] s;
        logic [7:0] hi;
        s = 8'd0;
        for (int i = 0; i < NW - 1; i++) begin
            image[i] = 16'(seed * 16'h3B1 + i * 16'h1F3) ^ 16'(i << 9);
            s = s + image[i][7:0] + image[i][15:8];
        end
        hi = 8'(seed * 7 + 3);
        image[NW-1] = {hi, 8'hFF - s - hi + (pass ? 8'd0 : 8'(1 + seed % 5))};
    endtask

    function automatic bit exp_valid();
        logic [7:0] s;
        s = 8'd0;
        for (int i = 0; i < NW; i++) s = s + image[i][7:0] + image[i][15:8];
        return s == 8'hFF;
    endfunction

    task automatic wait_idle();
        int n;
        n = 0;
        while (read_active && n < 5000) begin @(negedge clk); n++; end
        if (read_active) chk("R8 sequence never ended", 1, 0);
    endtask

    task automatic check_full(input string tag, input int base);
        chk({tag, " R2 serial clocks"}, edge_n, FULL);
        chk({tag, " R4 command bits"}, cmd_seen, 9'b110000000);
        chk({tag, " R5 word count"}, cap_total - base, NW);
        for (int i = 0; i < NW; i++) begin
            if (base + i < cap_total) begin
                chk({tag, " R5 word data"}, cap_data[base + i], image[i]);
                chk({tag, " R5 word addr"}, cap_addr[base + i], i);
            end
        end
        chk({tag, " R6 valid"}, load_valid, exp_valid());
        chk({tag, " R10 cs lead"}, rise1_t - cs_t, CLK_DIV / 2);
        chk({tag, " R10 period"}, rise2_t - rise1_t, CLK_DIV);
    endtask

    task automatic sw_run(input string tag, input bit probe_busy);
        int base;
        base = cap_total;
        @(negedge clk) sw_read_req = 1'b1;
        @(negedge clk) sw_read_req = 1'b0;
        chk({tag, " R8 busy at start"}, read_active, 1);
        chk({tag, " R9 valid cleared"}, load_valid, 0);
        if (probe_busy) begin
            repeat (100) @(negedge clk);
            sw_read_req = 1'b1;
            @(negedge clk) sw_read_req = 1'b0;
        end
        wait_idle();
        check_full(tag, base);
        repeat (10) @(negedge clk);
        chk({tag, " R8 no restart"}, read_active, 0);
        chk({tag, " R10 idle cs"}, mem_cs, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int base;
        make_image(1, 1'b1);
        strap_present = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", read_active, 0);
        chk("R1 cs in reset", mem_cs, 0);
        chk("R1 sck in reset", mem_sck, 0);
        chk("R1 valid in reset", load_valid, 0);
        chk("R1 we in reset", word_we, 0);

        // R2: boot load with device present
        base = cap_total;
        rst = 1'b0;
        @(negedge clk);
        chk("R2 busy after release", read_active, 1);
        wait_idle();
        check_full("boot", base);

        // R3: boot load with device absent
        @(negedge clk) rst = 1'b1; strap_present = 1'b0;
        make_image(2, 1'b1);
        repeat (3) @(negedge clk);
        base = cap_total;
        rst = 1'b0;
        @(negedge clk);
        chk("R3 busy during abort", read_active, 1);
        wait_idle();
        chk("R3 two serial clocks", edge_n, 2);
        chk("R3 no words", cap_total - base, 0);
        chk("R3 valid cleared", load_valid, 0);
        chk("R3 cs released", mem_cs, 0);

        // R7: software load ignores an absent strap
        sw_run("R7 strap0", 1'b0);
        chk("R7 valid on good image", load_valid, 1);

        // R8: request during a run is ignored
        make_image(3, 1'b0);
        sw_run("R8 busy probe", 1'b1);

        // R6 and R9 sweep over pass and fail images
        for (int s = 4; s < 12; s++) begin
            make_image(s, (s % 2) == 0);
            strap_present = (s % 3) == 0;
            sw_run("R6 sweep", 1'b0);
        end

        // R9: valid drops when a new run starts after a good one
        make_image(20, 1'b1);
        sw_run("R9 good", 1'b0);
        chk("R9 valid before rerun", load_valid, 1);
        make_image(21, 1'b0);
        sw_run("R9 rerun", 1'b0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule